// File: doc/BRIEF.md
# Private Timer Interrupt Edge Router

This block sits between the per-core timer and watchdog units and the interrupt controller. Each of those units drives a level interrupt line. The router watches the lines, finds each low-to-high transition and turns it into one pending-set request. The request names the core the source belongs to and the private interrupt number of the source kind. The controller receives a single request strobe with core and ID fields. The strobe has no backpressure, so every accepted edge is queued inside the router and sent in a later cycle.

The sources are arranged in pairs, two per core. Index `i` belongs to core `i>>1`. The even member of a pair is the timer and the odd member is the watchdog. A parameter sets the number of populated cores, up to a build-time maximum. Lines above the populated range are ignored.

Top module: `tir_router`

## Requirements
- R1: A request is raised only when a connected source is sampled high at a clock edge after being sampled low at the edge before. A source that stays high raises no further request.
- R2: The stored previous level of every source is refreshed at every clock edge, whether or not a request came from it. A source that falls and then rises again raises a second request.
- R3: The core field `req_core` of a request from source `i` equals `i>>1`.
- R4: `req_id` is `ID_TIMER` (default 29) for an even source and `ID_WDOG` (default 30) for an odd source.
- R5: Source lines with index `2*NUM_CORES` or higher never cause a request.
- R6: Rising edges seen in the same cycle, or while older requests still wait, are all kept. They are sent one per cycle, the lowest source index first, and none is lost.
- R7: During reset every stored level is zero and `req_vld`, `req_core` and `req_id` are zero. A source already high when reset is released therefore raises exactly one request.
- R8: A request is a `req_vld` pulse of one cycle per accepted edge. `req_core` and `req_id` are zero whenever `req_vld` is low. A rise sampled at clock edge k shows `req_vld` high in the cycle after edge k+1, when no older request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 2*MAX_CORES | Level interrupt lines; bit 2c is core c's timer, bit 2c+1 its watchdog |
| req_vld | output | 1 | Pending-set request strobe, one cycle per request |
| req_core | output | log2(2*MAX_CORES)-1 | Target core of the request |
| req_id | output | ID_W | Private interrupt number of the request |

## Verification
A stale or corrupt stored level shows up at the ports in one of two ways. A held-high line raises an extra request, or a fresh rise never raises one. The mismatch appears two cycles after the offending sample. A wrong pending set drops or duplicates requests in a burst, or changes their order, and this shows within one cycle per queued entry. Bad index decoding shows directly as a wrong core or ID in the same cycle as the strobe.

// File: rtl/tir_pkg.sv
package tir_pkg;
   typedef enum logic {SRC_TIMER = 1'b0, SRC_WDOG = 1'b1} src_kind_e;

   function automatic src_kind_e kind_of(input logic lsb);
      return lsb ? SRC_WDOG : SRC_TIMER;
   endfunction
endpackage

// File: rtl/tir_edge_det.sv
module tir_edge_det #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lvl,
   output logic [NSRC-1:0] rise
);
   logic [NSRC-1:0] prev_q;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[g] <= 1'b0;
         else        prev_q[g] <= lvl[g];
      end
      assign rise[g] = lvl[g] & ~prev_q[g];
   end
endmodule

// File: rtl/tir_pend_arb.sv
module tir_pend_arb #(
   parameter  int NSRC  = 8,
   localparam int IDX_W = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  set,
   output logic             gnt_vld,
   output logic [IDX_W-1:0] gnt_idx,
   output logic [NSRC-1:0]  gnt_oh
);
   logic [NSRC-1:0] pend_q;

   always_comb begin
      gnt_oh  = '0;
      gnt_idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            gnt_oh  = '0;
            gnt_oh[i] = 1'b1;
            gnt_idx = IDX_W'(i);
         end
      end
   end

   assign gnt_vld = |pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~gnt_oh) | set;
   end
endmodule

// File: rtl/tir_req_fmt.sv
module tir_req_fmt #(
   parameter  int IDX_W    = 3,
   parameter  int ID_W     = 5,
   parameter  int ID_TIMER = 29,
   parameter  int ID_WDOG  = 30,
   localparam int CORE_W   = IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gnt_vld,
   input  logic [IDX_W-1:0]  gnt_idx,
   output logic              req_vld,
   output logic [CORE_W-1:0] req_core,
   output logic [ID_W-1:0]   req_id
);
   import tir_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n || !gnt_vld) begin
         req_vld  <= 1'b0;
         req_core <= '0;
         req_id   <= '0;
      end else begin
         req_vld  <= 1'b1;
         req_core <= gnt_idx[IDX_W-1:1];
         req_id   <= (kind_of(gnt_idx[0]) == SRC_WDOG) ? ID_W'(ID_WDOG) : ID_W'(ID_TIMER);
      end
   end
endmodule

// File: rtl/tir_router.sv
module tir_router #(
   parameter  int MAX_CORES = 4,
   parameter  int NUM_CORES = 4,
   parameter  int ID_W      = 5,
   parameter  int ID_TIMER  = 29,
   parameter  int ID_WDOG   = 30,
   localparam int NSRC      = 2 * MAX_CORES,
   localparam int IDX_W     = $clog2(NSRC),
   localparam int CORE_W    = IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_lvl,
   output logic              req_vld,
   output logic [CORE_W-1:0] req_core,
   output logic [ID_W-1:0]   req_id
);
   if (MAX_CORES < 2 || (MAX_CORES & (MAX_CORES - 1)) != 0)
      $error("MAX_CORES must be a power of two of at least 2");
   if (NUM_CORES < 1 || NUM_CORES > MAX_CORES)
      $error("NUM_CORES out of range");
   if (ID_TIMER >= (1 << ID_W) || ID_WDOG >= (1 << ID_W) || ID_TIMER == ID_WDOG)
      $error("interrupt IDs must differ and fit ID_W");

   logic [NSRC-1:0]  rise_raw, rise_used, gnt_oh;
   logic             gnt_vld;
   logic [IDX_W-1:0] gnt_idx;

   tir_edge_det #(.NSRC(NSRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .rise(rise_raw)
   );

   for (genvar g = 0; g < NSRC; g++) begin : g_mask
      if (g < 2 * NUM_CORES) begin : g_live
         assign rise_used[g] = rise_raw[g];
      end else begin : g_dead
         assign rise_used[g] = 1'b0 & rise_raw[g];
      end
   end

   tir_pend_arb #(.NSRC(NSRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .set(rise_used),
      .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .gnt_oh(gnt_oh)
   );

   tir_req_fmt #(.IDX_W(IDX_W), .ID_W(ID_W), .ID_TIMER(ID_TIMER), .ID_WDOG(ID_WDOG)) u_fmt (
      .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
      .req_vld(req_vld), .req_core(req_core), .req_id(req_id)
   );
endmodule

// File: rtl/tir_router_chk.sv
module tir_router_chk #(
   parameter int NSRC      = 8,
   parameter int CORE_W    = 2,
   parameter int ID_W      = 5,
   parameter int NUM_CORES = 4,
   parameter int ID_TIMER  = 29,
   parameter int ID_WDOG   = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic [CORE_W-1:0] req_core,
   input logic [ID_W-1:0]   req_id,
   input logic [NSRC-1:0]   gnt_oh
);
   a_r3_core_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> req_core <= CORE_W'(NUM_CORES - 1));

   a_r4_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |-> (req_id == ID_W'(ID_TIMER) || req_id == ID_W'(ID_WDOG)));

   a_r8_idle_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |-> (req_core == '0 && req_id == '0));

   a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !req_vld);

   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_oh));
endmodule

bind tir_router tir_router_chk #(
   .NSRC(NSRC), .CORE_W(CORE_W), .ID_W(ID_W), .NUM_CORES(NUM_CORES),
   .ID_TIMER(ID_TIMER), .ID_WDOG(ID_WDOG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_core(req_core),
   .req_id(req_id), .gnt_oh(gnt_oh)
);

// File: tb/tir_router_test.sv
module tir_router_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src = '0, src2 = '0;
   logic       vld, vld2;
   logic [1:0] core, core2;
   logic [4:0] id, id2;
   int         errors = 0, checks = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   tir_router uut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src),
      .req_vld(vld), .req_core(core), .req_id(id)
   );

   tir_router #(.NUM_CORES(2)) uut_n2 (
      .clk(clk), .rst_n(rst_n), .src_lvl(src2),
      .req_vld(vld2), .req_core(core2), .req_id(id2)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic exp_req(input string tag, input int c, input int i);
      chk({tag, " vld"}, int'(vld), 1);
      chk({tag, " core"}, int'(core), c);
      chk({tag, " id"}, int'(id), i);
   endtask

   task automatic exp_idle(input string tag);
      chk({tag, " vld"}, int'(vld), 0);
      chk({tag, " core"}, int'(core), 0);
      chk({tag, " id"}, int'(id), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      exp_idle("R7 in reset");
      chk("R7 in reset n2 vld", int'(vld2), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      exp_idle("R7 after release all low");
   endtask

   task automatic t_single();
      src[0] = 1'b1;
      @(negedge clk);
      exp_idle("R8 latency first cycle");
      @(negedge clk);
      exp_req("R1 timer core0", 0, 29);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         exp_idle("R1 R8 held high no repeat");
      end
      src[0] = 1'b0;
      repeat (3) @(negedge clk);
      exp_idle("R1 fall gives nothing");
   endtask

   task automatic t_wdog();
      src[5] = 1'b1;
      repeat (2) @(negedge clk);
      exp_req("R3 R4 watchdog src5", 2, 30);
      @(negedge clk);
      exp_idle("R8 one strobe");
      src = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_burst();
      src = 8'hFF;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         exp_req("R6 R3 R4 burst order", i >> 1, (i & 1) ? 30 : 29);
      end
      @(negedge clk);
      exp_idle("R6 burst drained");
      src = '0;
      repeat (3) @(negedge clk);
      exp_idle("R1 burst fall quiet");
   endtask

   task automatic t_retrigger();
      src[2] = 1'b1;
      @(negedge clk);
      src[2] = 1'b0;
      @(negedge clk);
      exp_req("R2 first rise src2", 1, 29);
      src[2] = 1'b1;
      @(negedge clk);
      exp_idle("R2 gap");
      @(negedge clk);
      exp_req("R2 second rise src2", 1, 29);
      @(negedge clk);
      exp_idle("R2 held after second");
      src = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_unused();
      src2 = 8'hF0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R5 unused lines vld", int'(vld2), 0);
      end
      src2 = 8'hF2;
      repeat (2) @(negedge clk);
      chk("R5 live src1 vld", int'(vld2), 1);
      chk("R5 live src1 core", int'(core2), 0);
      chk("R5 live src1 id", int'(id2), 30);
      src2 = 8'h02;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R5 unused fall quiet", int'(vld2), 0);
      end
      src2 = 8'hF2;
      @(negedge clk);
      @(negedge clk);
      chk("R5 unused re-rise quiet", int'(vld2), 0);
      src2 = '0;
   endtask

   task automatic t_reset_high();
      @(negedge clk);
      src = 8'h08;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      exp_idle("R7 reset with line high");
      rst_n = 1'b1;
      @(negedge clk);
      exp_idle("R7 first cycle after release");
      @(negedge clk);
      exp_req("R7 high at release src3", 1, 30);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         exp_idle("R7 only one request");
      end
      src = '0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      t_reset();
      t_single();
      t_wdog();
      t_burst();
      t_retrigger();
      t_unused();
      t_reset_high();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule